// File: doc/BRIEF.md
# Indexed Register Port with Interrupt Status

This block sits between a byte-wide two-address bus and a real-time clock core. A write to the even address loads a 7-bit pointer. An access to the odd address then reads or writes the byte that the pointer selects, anywhere in a 128-byte space. Four of those bytes are control and status registers:

- **A** (index 0x0A): divider and rate control, with an update-in-progress bit.
- **B** (index 0x0B): mode and interrupt enables.
- **C** (index 0x0C): interrupt flags.
- **D** (index 0x0D): a constant valid byte.

Every other index is plain storage. The clock and periodic timer logic live outside the block. They send one-cycle flag pulses in (periodic, alarm, update-ended) and pulses that set or clear the update-in-progress bit, and they read registers A and B back through the control outputs.

The interrupt request is a level controlled by a two-state machine:

- QUIET: the request is low. QUIET moves to RAISED on an enabled, newly set flag. It also moves to RAISED on a write of B that enables a flag which is already pending.
- RAISED: the request is high. RAISED stays RAISED while neither of those clearing events occurs. It returns to QUIET on a read of register C, on a write of B that leaves no pending flag enabled, or on a system reset.

The IRQF bit of C reads as the state of this machine.

Odd-address reads are registered. The read data appears on the output one clock after the access strobe and holds until the next read.

Top module: `rtcp_top`

## Requirements
- R1: A write to the even address stores bus_wdata[6:0] as the index, and bit 7 is discarded. A read from the even address returns 0xFF. Odd-address accesses target the byte the index selects, with read data valid one cycle after the strobe.
- R2: After the asynchronous reset, register A reads 0x26, B reads 0x02, C reads 0x00 and D reads 0x80. The interrupt output is low.
- R3: Writes to register C (0x0C) and register D (0x0D) change neither their read value nor the interrupt output.
- R4: Reading register C returns its current value, then clears all of C to 0x00 and drops the interrupt output on the next cycle.
- R5: Register A bit 7 (update in progress) is set by uip_set and cleared by uip_clr. A write of A keeps bit 7's current value and stores bits 6:0.
- R6: A write of B with bit 7 (SET) = 1 stores bit 4 (update-ended enable) as 0 and clears A bit 7.
- R7: A write of B whose enables (bits 6, 5, 4: periodic, alarm, update) match a flag already set in C (bits 6, 5, 4) sets IRQF (C bit 7) and raises the interrupt. Any other write of B clears IRQF and drops the interrupt.
- R8: A flag pulse sets its C bit. It raises IRQF and the interrupt only when the flag was clear before and its matching B enable is set. A disabled flag is stored without raising anything.
- R9: soft_rst clears B bits 6, 5 and 3 (periodic, alarm and square-wave enables), clears all of C, and drops the interrupt. It leaves the other B bits unchanged.
- R10: The interrupt output is a level. It holds until register C is read, B is written or soft_rst is asserted, and IRQF always reads equal to it.
- R11: A flag pulse in the same cycle as a read of C is not in the returned value but remains set in C afterwards. If enabled, it raises the interrupt.
- R12: General-purpose bytes, including index 0x7F, read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to the power-up values |
| soft_rst | input | 1 | Synchronous system reset of enables, flags and interrupt |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_odd | input | 1 | 0 = index address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pf_pulse | input | 1 | Periodic flag set pulse |
| af_pulse | input | 1 | Alarm flag set pulse |
| uf_pulse | input | 1 | Update-ended flag set pulse |
| uip_set | input | 1 | Sets update-in-progress |
| uip_clr | input | 1 | Clears update-in-progress |
| ctrl_a | output | 8 | Current register A |
| ctrl_b | output | 8 | Current register B |
| irq_o | output | 1 | Interrupt request level |

## Verification
The hardest case to reach from the ports is a collision of events in a single clock edge.

The first collision is a flag pulse landing in the same cycle as the read that clears register C. The bench drives the C read strobe and af_pulse together from one task. It then checks that the returned byte omits the alarm flag, that the interrupt rises on the next edge, and that a second read shows the flag.

The second collision is an enable written while its flag is already pending. The bench creates a pending, disabled periodic flag first, then writes B with that enable set and checks that the interrupt rises without any pulse.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
    localparam int unsigned IDX_W  = 7;
    localparam int unsigned DATA_W = 8;

    localparam logic [IDX_W-1:0] IDX_CTRL_A = 7'h0A;
    localparam logic [IDX_W-1:0] IDX_CTRL_B = 7'h0B;
    localparam logic [IDX_W-1:0] IDX_STAT_C = 7'h0C;
    localparam logic [IDX_W-1:0] IDX_STAT_D = 7'h0D;

    localparam logic [DATA_W-1:0] RST_A = 8'h26;
    localparam logic [DATA_W-1:0] RST_B = 8'h02;
    localparam logic [DATA_W-1:0] VAL_D = 8'h80;
    localparam logic [DATA_W-1:0] EVEN_RD = 8'hFF;

    // bit positions decoded by software and by the clock core
    localparam int unsigned B_SET  = 7;
    localparam int unsigned B_UIE  = 4;
    // enables cleared by a system reset: periodic, alarm, square wave
    localparam logic [DATA_W-1:0] B_SOFT_MASK = 8'h68;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/rtcp_index_port.sv
module rtcp_index_port #(
    parameter int unsigned IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_odd,
    input  logic [IDX_W-1:0] idx_data,
    output logic [IDX_W-1:0] idx_q,
    output logic             acc_rd,
    output logic             acc_wr,
    output logic             acc_rd_even
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (bus_sel && bus_wr && !bus_odd) begin
            idx_q <= idx_data;
        end
    end

    always_comb begin
        acc_rd      = bus_sel && !bus_wr && bus_odd;
        acc_wr      = bus_sel && bus_wr && bus_odd;
        acc_rd_even = bus_sel && !bus_wr && !bus_odd;
    end
endmodule

// File: rtl/rtcp_ctrl_regs.sv
module rtcp_ctrl_regs
    import rtcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata,
    input  logic              uip_set,
    input  logic              uip_clr,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic [DATA_W-1:0] b_wval
);
    logic [DATA_W-2:0] a_low_q;
    logic              uip_q;
    logic [DATA_W-1:0] b_q;
    logic [DATA_W-1:0] b_d;
    logic              set_wr;

    always_comb begin
        set_wr = wr_b && wdata[B_SET];
        b_wval = wdata;
        if (wdata[B_SET]) begin
            b_wval[B_UIE] = 1'b0;
        end
        b_d = wr_b ? b_wval : b_q;
        if (soft_rst) begin
            b_d = b_d & ~B_SOFT_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_low_q <= RST_A[DATA_W-2:0];
            uip_q   <= RST_A[DATA_W-1];
            b_q     <= RST_B;
        end else begin
            if (wr_a) begin
                a_low_q <= wdata[DATA_W-2:0];
            end
            if (set_wr || uip_clr) begin
                uip_q <= 1'b0;
            end else if (uip_set) begin
                uip_q <= 1'b1;
            end
            b_q <= b_d;
        end
    end

    assign reg_a = {uip_q, a_low_q};
    assign reg_b = b_q;
endmodule

// File: rtl/rtcp_irq_status.sv
module rtcp_irq_status
    import rtcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rd_c,
    input  logic              wr_b,
    input  logic [2:0]        b_wen,
    input  logic [2:0]        b_en,
    input  logic [2:0]        evt,
    output logic [DATA_W-1:0] c_val,
    output logic              irq_o
);
    irq_state_e state_q, state_d;
    logic [2:0] flags_q, flags_d;
    logic [2:0] flags_mid, fresh, en_now;
    logic       keep, raise;

    // next-state and flag merge
    always_comb begin
        flags_mid = rd_c ? 3'b000 : flags_q;
        fresh     = evt & ~flags_mid;
        en_now    = wr_b ? b_wen : b_en;
        raise     = |(fresh & en_now);
        flags_d   = flags_mid | evt;
        keep      = 1'b0;
        unique case (state_q)
            IRQ_QUIET: begin
                keep    = wr_b && |(b_wen & flags_q);
                state_d = (raise || keep) ? IRQ_RAISED : IRQ_QUIET;
            end
            IRQ_RAISED: begin
                keep    = wr_b ? |(b_wen & flags_q) : !rd_c;
                state_d = (raise || keep) ? IRQ_RAISED : IRQ_QUIET;
            end
            default: state_d = IRQ_QUIET;
        endcase
        if (soft_rst) begin
            flags_d = 3'b000;
            state_d = IRQ_QUIET;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
            flags_q <= 3'b000;
        end else begin
            state_q <= state_d;
            flags_q <= flags_d;
        end
    end

    // outputs
    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
        c_val = {irq_o, flags_q, 4'b0000};
    end
endmodule

// File: rtl/rtcp_gp_store.sv
module rtcp_gp_store #(
    parameter int unsigned IDX_W  = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/rtcp_top.sv
module rtcp_top
    import rtcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_odd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pf_pulse,
    input  logic              af_pulse,
    input  logic              uf_pulse,
    input  logic              uip_set,
    input  logic              uip_clr,
    output logic [DATA_W-1:0] ctrl_a,
    output logic [DATA_W-1:0] ctrl_b,
    output logic              irq_o
);
    logic [IDX_W-1:0]  idx_q;
    logic              acc_rd, acc_wr, acc_rd_even;
    logic              hit_a, hit_b, hit_c, hit_d;
    logic              wr_a, wr_b, rd_c, wr_gp;
    logic [DATA_W-1:0] b_wval, c_val, gp_rdata, rd_mux, rdata_q;

    rtcp_index_port #(.IDX_W(IDX_W)) u_index (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_odd     (bus_odd),
        .idx_data    (bus_wdata[IDX_W-1:0]),
        .idx_q       (idx_q),
        .acc_rd      (acc_rd),
        .acc_wr      (acc_wr),
        .acc_rd_even (acc_rd_even)
    );

    always_comb begin
        hit_a = (idx_q == IDX_CTRL_A);
        hit_b = (idx_q == IDX_CTRL_B);
        hit_c = (idx_q == IDX_STAT_C);
        hit_d = (idx_q == IDX_STAT_D);
        wr_a  = acc_wr && hit_a;
        wr_b  = acc_wr && hit_b;
        rd_c  = acc_rd && hit_c;
        wr_gp = acc_wr && !(hit_a || hit_b || hit_c || hit_d);
    end

    rtcp_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_a     (wr_a),
        .wr_b     (wr_b),
        .wdata    (bus_wdata),
        .uip_set  (uip_set),
        .uip_clr  (uip_clr),
        .reg_a    (ctrl_a),
        .reg_b    (ctrl_b),
        .b_wval   (b_wval)
    );

    rtcp_irq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .rd_c     (rd_c),
        .wr_b     (wr_b),
        .b_wen    (b_wval[6:4]),
        .b_en     (ctrl_b[6:4]),
        .evt      ({pf_pulse, af_pulse, uf_pulse}),
        .c_val    (c_val),
        .irq_o    (irq_o)
    );

    rtcp_gp_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_gp (
        .clk   (clk),
        .wr_en (wr_gp),
        .idx   (idx_q),
        .wdata (bus_wdata),
        .rdata (gp_rdata)
    );

    always_comb begin
        unique case (1'b1)
            hit_a:   rd_mux = ctrl_a;
            hit_b:   rd_mux = ctrl_b;
            hit_c:   rd_mux = c_val;
            hit_d:   rd_mux = VAL_D;
            default: rd_mux = gp_rdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (acc_rd_even) begin
            rdata_q <= EVEN_RD;
        end else if (acc_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/rtcp_sva.sv
module rtcp_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic       bus_odd,
    input logic [7:0] bus_wdata,
    input logic       pf_pulse,
    input logic       af_pulse,
    input logic       uf_pulse,
    input logic       uip_set,
    input logic       uip_clr,
    input logic [6:0] idx_q,
    input logic [7:0] ctrl_a,
    input logic [7:0] ctrl_b,
    input logic       irq_o
);
    logic evt_any, odd_wr, rd_c, wr_a, wr_b, wr_c;

    always_comb begin
        evt_any = pf_pulse || af_pulse || uf_pulse;
        odd_wr  = bus_sel && bus_wr && bus_odd;
        rd_c    = bus_sel && !bus_wr && bus_odd && (idx_q == 7'h0C);
        wr_a    = odd_wr && (idx_q == 7'h0A);
        wr_b    = odd_wr && (idx_q == 7'h0B);
        wr_c    = odd_wr && (idx_q == 7'h0C);
    end

    assert_c_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c && !evt_any && !soft_rst |=> $stable(irq_o));

    assert_c_read_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c && !evt_any && !soft_rst |=> !irq_o);

    assert_uip_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a && !uip_set && !uip_clr |=> ctrl_a[7] == $past(ctrl_a[7]));

    assert_set_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b && bus_wdata[7] |=> !ctrl_b[4] && !ctrl_a[7]);

    assert_no_spurious_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o && !wr_b && !evt_any |=> !irq_o);

    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !irq_o && (ctrl_b[6:5] == 2'b00) && !ctrl_b[3]);

    assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !rd_c && !wr_b && !soft_rst |=> irq_o);
endmodule

bind rtcp_top rtcp_sva chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_odd   (bus_odd),
    .bus_wdata (bus_wdata),
    .pf_pulse  (pf_pulse),
    .af_pulse  (af_pulse),
    .uf_pulse  (uf_pulse),
    .uip_set   (uip_set),
    .uip_clr   (uip_clr),
    .idx_q     (idx_q),
    .ctrl_a    (ctrl_a),
    .ctrl_b    (ctrl_b),
    .irq_o     (irq_o)
);

// File: tb/rtcp_top_tb_top.sv
`timescale 1ns/1ps
module rtcp_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_odd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pf_pulse = 1'b0;
    logic       af_pulse = 1'b0;
    logic       uf_pulse = 1'b0;
    logic       uip_set = 1'b0;
    logic       uip_clr = 1'b0;
    logic [7:0] ctrl_a, ctrl_b;
    logic       irq_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    rtcp_top dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_odd(bus_odd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pf_pulse(pf_pulse), .af_pulse(af_pulse), .uf_pulse(uf_pulse),
        .uip_set(uip_set), .uip_clr(uip_clr),
        .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq_o(irq_o)
    );

    // op codes: 0 index write, 1 data write, 2 data read, 3 even read, 4 flag pulse (data[6:4])
    localparam int NV = 31;
    localparam logic [19:0] VEC [NV] = '{
        {3'd3, 8'h00, 8'hFF, 1'b0},   // R1 even read
        {3'd0, 8'h0A, 8'h00, 1'b0},
        {3'd2, 8'h00, 8'h26, 1'b0},   // R2
        {3'd0, 8'h0B, 8'h00, 1'b0},
        {3'd2, 8'h00, 8'h02, 1'b0},   // R2
        {3'd0, 8'h0C, 8'h00, 1'b0},
        {3'd2, 8'h00, 8'h00, 1'b0},   // R2
        {3'd0, 8'h0D, 8'h00, 1'b0},
        {3'd2, 8'h00, 8'h80, 1'b0},   // R2
        {3'd1, 8'h55, 8'h00, 1'b0},
        {3'd2, 8'h00, 8'h80, 1'b0},   // R3 D ignores write
        {3'd0, 8'h0C, 8'h00, 1'b0},
        {3'd1, 8'hFF, 8'h00, 1'b0},
        {3'd2, 8'h00, 8'h00, 1'b0},   // R3 C ignores write
        {3'd0, 8'h7F, 8'h00, 1'b0},
        {3'd1, 8'h5A, 8'h00, 1'b0},
        {3'd0, 8'h8E, 8'h00, 1'b0},   // R1 bit 7 dropped -> 0x0E
        {3'd1, 8'h3C, 8'h00, 1'b0},
        {3'd0, 8'h0E, 8'h00, 1'b0},
        {3'd2, 8'h00, 8'h3C, 1'b0},   // R1
        {3'd0, 8'h7F, 8'h00, 1'b0},
        {3'd2, 8'h00, 8'h5A, 1'b0},   // R12
        {3'd0, 8'h0B, 8'h00, 1'b0},
        {3'd1, 8'h22, 8'h00, 1'b0},
        {3'd4, 8'h20, 8'h00, 1'b1},   // R8 enabled alarm
        {3'd0, 8'h0C, 8'h00, 1'b1},   // R10 holds
        {3'd2, 8'h00, 8'hA0, 1'b0},   // R4
        {3'd2, 8'h00, 8'h00, 1'b0},   // R4 cleared
        {3'd4, 8'h10, 8'h00, 1'b0},   // R8 disabled update flag
        {3'd2, 8'h00, 8'h10, 1'b0},   // R8 stored
        {3'd1, 8'h00, 8'h00, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // starts at a negedge, ends at the next negedge
    task automatic bus_op(input logic wr, input logic odd, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = wr; bus_odd = odd; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m);
        pf_pulse = m[6]; af_pulse = m[5]; uf_pulse = m[4];
        @(negedge clk);
        pf_pulse = 1'b0; af_pulse = 1'b0; uf_pulse = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
        bus_op(1'b1, 1'b0, i);
        bus_op(1'b1, 1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] i, input string req, input logic [7:0] exp);
        bus_op(1'b1, 1'b0, i);
        bus_op(1'b0, 1'b1, 8'h00);
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 ctrl_a", ctrl_a, 8'h26);
        check("R2 ctrl_b", ctrl_b, 8'h02);
        check("R2 irq", irq_o, 0);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] op;
            logic [7:0] d, e;
            logic       ei;
            {op, d, e, ei} = VEC[i];
            case (op)
                3'd0: bus_op(1'b1, 1'b0, d);
                3'd1: bus_op(1'b1, 1'b1, d);
                3'd2: begin bus_op(1'b0, 1'b1, 8'h00); check($sformatf("R1/R4 row %0d rdata", i), bus_rdata, e); end
                3'd3: begin bus_op(1'b0, 1'b0, 8'h00); check($sformatf("R1 row %0d even", i), bus_rdata, e); end
                default: pulse(d);
            endcase
            check($sformatf("R8/R10 row %0d irq", i), irq_o, ei);
        end

        // R7: pending disabled flag, then enable it
        reg_wr(8'h0B, 8'h02);
        pulse(8'h40);
        check("R8 disabled pf no irq", irq_o, 0);
        reg_wr(8'h0B, 8'h42);
        check("R7 enable with pending flag", irq_o, 1);
        reg_rd(8'h0C, "R7 IRQF and PF", 8'hC0);
        check("R4 irq low after read", irq_o, 0);
        pulse(8'h40);
        check("R8 enabled new pf", irq_o, 1);
        repeat (4) @(negedge clk);
        check("R10 level hold", irq_o, 1);
        reg_wr(8'h0B, 8'h02);
        check("R7 B write drops irq", irq_o, 0);
        reg_rd(8'h0C, "R7 IRQF cleared", 8'h40);

        // R5 / R6
        uip_set = 1'b1; @(negedge clk); uip_set = 1'b0;
        reg_rd(8'h0A, "R5 uip set", 8'hA6);
        reg_wr(8'h0A, 8'h2F);
        check("R5 uip kept on write", ctrl_a, 8'hAF);
        reg_wr(8'h0B, 8'h92);
        check("R6 UIE forced 0", ctrl_b, 8'h82);
        check("R6 uip cleared", ctrl_a, 8'h2F);
        uip_set = 1'b1; @(negedge clk); uip_set = 1'b0;
        uip_clr = 1'b1; @(negedge clk); uip_clr = 1'b0;
        check("R5 uip clear", ctrl_a, 8'h2F);

        // R11: pulse collides with read of C
        reg_wr(8'h0B, 8'h22);
        reg_rd(8'h0C, "R11 C empty", 8'h00);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_odd = 1'b1; af_pulse = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; af_pulse = 1'b0;
        check("R11 returned value", bus_rdata, 8'h00);
        check("R11 irq raised", irq_o, 1);
        bus_op(1'b0, 1'b1, 8'h00);
        check("R11 flag kept", bus_rdata, 8'hA0);

        // R9
        reg_wr(8'h0B, 8'h7A);
        pulse(8'h20);
        check("R9 pre irq", irq_o, 1);
        soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        check("R9 irq low", irq_o, 0);
        check("R9 B masked", ctrl_b, 8'h12);
        reg_rd(8'h0C, "R9 C cleared", 8'h00);
        reg_rd(8'h0D, "R3 D constant", 8'h80);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule